// File: doc/BRIEF.md
# Atomic-Update GPIO Port

A 32-pin general-purpose I/O port programmed through a flat word-addressed register bus. Eight control vectors hold per-pin state: a GPIO ownership bit, an output enable, an output level, a pull-up enable, a pull-down enable, and three bit planes that together form a 3-bit peripheral-function selector. Each control vector sits behind four bus aliases: plain write, set, clear and toggle. Software can therefore flip one pin's bit with a single write and never needs a read-modify-write sequence that an interrupt could break.

When a pin's ownership bit is set, the port's own output level and output-enable vectors drive the pad. When it is clear, one of eight peripheral functions drives the pad. The function is chosen by the pin's selector. The pull enables are decoded into pull-up, pull-down or bus-keeper pad controls. The pad input is resynchronised by two flops and can be read back at any time, in either mode. Open-drain signalling is done by holding the output level at 0 and toggling the output enable.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset every ownership bit reads 1. Output enable, output level, both pull enables and all three selector planes read 0. Every pad output enable is 0.
- R2: A bus word address is {index[3:0], op[1:0]}. With op 00, a write replaces the whole control vector at that index with the write data.
- R3: With op 01 (set alias), each 1 in the write data sets the matching control bit. Bits written as 0 keep their value.
- R4: With op 10 (clear alias), each 1 in the write data clears the matching control bit. Bits written as 0 keep their value.
- R5: With op 11 (toggle alias), each 1 in the write data inverts the matching control bit. Bits written as 0 keep their value.
- R6: Reading any of the four aliases of an index returns that control vector, with no added latency. The indices are: 0 ownership, 1 output enable, 2 output level, 3 pull-up, 4 pull-down, 5 selector plane 0, 6 selector plane 1, 7 selector plane 2.
- R7: Index 8 reads the pad input after two rising clock edges of synchronisation, in GPIO or peripheral mode. Writes to index 8 and above change nothing. Reads of index 9 and above return 0.
- R8: On a pin whose ownership bit is 1, the pad output equals the output-level bit and the pad enable equals the output-enable bit.
- R9: On a pin p whose ownership bit is 0, the function f = {plane2, plane1, plane0} drives the pad with periph_out[f*32+p] and periph_oe[f*32+p].
- R10: With pull-up only set, pad_pullup is asserted. With pull-down only set, pad_pulldown is asserted. With both set, only pad_keeper is asserted. At most one of the three is high per pin.
- R11: With the output level held at 0, each toggle-alias write to the output-enable vector alternates the pin between driven low and released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Word address {index, op} |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Level driven to each pad |
| pad_oe | output | 32 | Pad driver enable |
| pad_pullup | output | 32 | Pull-up control |
| pad_pulldown | output | 32 | Pull-down control |
| pad_keeper | output | 32 | Bus-keeper control |
| periph_out | input | 256 | Peripheral output levels, function-major |
| periph_oe | input | 256 | Peripheral output enables, function-major |

## Verification
The bound checker covers the following on every cycle: the arithmetic of the plain, set, clear and toggle aliases on the enable and level vectors, pad drive on GPIO-owned pins, mutual exclusion of the pull controls, the two-cycle input delay, and the stability of the control vectors across writes to unmapped indices. Some behaviour is left to the bench's scenarios, where a behavioural model is compared against the outputs each cycle. This covers the reset values, the read map, selection among eight peripheral functions, the bus-keeper decode and the open-drain toggle sequence.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_SET    = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_TOGGLE = 2'b11
    } alias_op_e;

    typedef enum logic [1:0] {
        PULL_OFF  = 2'b00,
        PULL_UP   = 2'b01,
        PULL_DOWN = 2'b10,
        PULL_KEEP = 2'b11
    } pull_mode_e;

    localparam int IDX_OWN  = 0;
    localparam int IDX_OE   = 1;
    localparam int IDX_OUT  = 2;
    localparam int IDX_PU   = 3;
    localparam int IDX_PD   = 4;
    localparam int IDX_MUX0 = 5;

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_port_pkg::*;
#(
    parameter int          WIDTH     = 32,
    parameter logic        RESET_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  alias_op_e        op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] next_q;

    always_comb begin
        unique case (op)
            OP_WRITE:  next_q = wdata;
            OP_SET:    next_q = q | wdata;
            OP_CLEAR:  next_q = q & ~wdata;
            OP_TOGGLE: next_q = q ^ wdata;
            default:   next_q = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= {WIDTH{RESET_BIT}};
        end else if (wr_en) begin
            q <= next_q;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_driver.sv
module gpio_pin_driver
    import gpio_port_pkg::*;
#(
    parameter int NUM_FUNCS = 8,
    parameter int SEL_W     = 3
) (
    input  logic                 own,
    input  logic                 gpio_out,
    input  logic                 gpio_oe,
    input  logic [SEL_W-1:0]     func_sel,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    input  logic                 pull_up_en,
    input  logic                 pull_dn_en,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 pad_pu,
    output logic                 pad_pd,
    output logic                 pad_keep
);

    pull_mode_e pull_mode;

    always_comb begin
        if (own) begin
            pad_out = gpio_out;
            pad_oe  = gpio_oe;
        end else if (int'(func_sel) < NUM_FUNCS) begin
            pad_out = fn_out[func_sel];
            pad_oe  = fn_oe[func_sel];
        end else begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
        end
    end

    assign pull_mode = pull_mode_e'({pull_dn_en, pull_up_en});

    always_comb begin
        pad_pu   = 1'b0;
        pad_pd   = 1'b0;
        pad_keep = 1'b0;
        unique case (pull_mode)
            PULL_OFF:  ;
            PULL_UP:   pad_pu   = 1'b1;
            PULL_DOWN: pad_pd   = 1'b1;
            PULL_KEEP: pad_keep = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int NUM_FUNCS   = 8,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [NUM_PINS-1:0]           bus_wdata,
    output logic [NUM_PINS-1:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]           pad_in,
    output logic [NUM_PINS-1:0]           pad_out,
    output logic [NUM_PINS-1:0]           pad_oe,
    output logic [NUM_PINS-1:0]           pad_pullup,
    output logic [NUM_PINS-1:0]           pad_pulldown,
    output logic [NUM_PINS-1:0]           pad_keeper,
    input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_out,
    input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_oe
);

    localparam int SEL_W          = $clog2(NUM_FUNCS);
    localparam int NUM_CTRL_REGS  = IDX_MUX0 + SEL_W;
    localparam int LEVEL_IDX      = NUM_CTRL_REGS;
    localparam int IDX_W          = ADDR_W - 2;

    logic [IDX_W-1:0]    reg_idx;
    alias_op_e           reg_op;
    logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL_REGS];
    logic [NUM_PINS-1:0] level_q;
    logic [NUM_PINS-1:0] own_q;
    logic [NUM_PINS-1:0] oe_q;
    logic [NUM_PINS-1:0] out_q;

    assign reg_idx = bus_addr[ADDR_W-1:2];
    assign reg_op  = alias_op_e'(bus_addr[1:0]);

    // Control vectors, each behind four aliases
    for (genvar r = 0; r < NUM_CTRL_REGS; r++) begin : g_ctrl
        gpio_alias_reg #(
            .WIDTH     (NUM_PINS),
            .RESET_BIT ((r == IDX_OWN) ? 1'b1 : 1'b0)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && (reg_idx == IDX_W'(r))),
            .op    (reg_op),
            .wdata (bus_wdata),
            .q     (ctrl_q[r])
        );
    end

    assign own_q = ctrl_q[IDX_OWN];
    assign oe_q  = ctrl_q[IDX_OE];
    assign out_q = ctrl_q[IDX_OUT];

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (level_q)
    );

    // Read path
    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NUM_CTRL_REGS; r++) begin
            if (reg_idx == r[IDX_W-1:0]) begin
                bus_rdata = ctrl_q[r];
            end
        end
        if (reg_idx == LEVEL_IDX[IDX_W-1:0]) begin
            bus_rdata = level_q;
        end
    end

    // Per-pin drive and pull decode
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [SEL_W-1:0]     sel;
        logic [NUM_FUNCS-1:0] fn_out;
        logic [NUM_FUNCS-1:0] fn_oe;

        for (genvar k = 0; k < SEL_W; k++) begin : g_plane
            assign sel[k] = ctrl_q[IDX_MUX0 + k][p];
        end

        for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
            assign fn_out[f] = periph_out[f*NUM_PINS + p];
            assign fn_oe[f]  = periph_oe[f*NUM_PINS + p];
        end

        gpio_pin_driver #(
            .NUM_FUNCS (NUM_FUNCS),
            .SEL_W     (SEL_W)
        ) u_drv (
            .own        (own_q[p]),
            .gpio_out   (out_q[p]),
            .gpio_oe    (oe_q[p]),
            .func_sel   (sel),
            .fn_out     (fn_out),
            .fn_oe      (fn_oe),
            .pull_up_en (ctrl_q[IDX_PU][p]),
            .pull_dn_en (ctrl_q[IDX_PD][p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p]),
            .pad_pu     (pad_pullup[p]),
            .pad_pd     (pad_pulldown[p]),
            .pad_keep   (pad_keeper[p])
        );
    end

endmodule

// File: rtl/gpio_atomic_port_checker.sv
module gpio_atomic_port_checker #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int NUM_CTRL = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_pullup,
    input logic [NUM_PINS-1:0] pad_pulldown,
    input logic [NUM_PINS-1:0] pad_keeper,
    input logic [NUM_PINS-1:0] own_q,
    input logic [NUM_PINS-1:0] oe_q,
    input logic [NUM_PINS-1:0] out_q,
    input logic [NUM_PINS-1:0] level_q
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       op;
    logic [1:0]       since_rst;

    assign idx = bus_addr[ADDR_W-1:2];
    assign op  = bus_addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(1) && op == 2'b00) |=> (oe_q == $past(bus_wdata)));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(1) && op == 2'b01) |=>
            (((oe_q & $past(bus_wdata)) == $past(bus_wdata)) &&
             ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata)))));

    assert_clear_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(2) && op == 2'b10) |=>
            (((out_q & $past(bus_wdata)) == '0) &&
             ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

    assert_toggle_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(1) && op == 2'b11) |=>
            ((oe_q ^ $past(oe_q)) == $past(bus_wdata)));

    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(idx) >= NUM_CTRL) |=>
            ($stable(own_q) && $stable(oe_q) && $stable(out_q)));

    assert_level_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (level_q == $past(pad_in, 2)));

    assert_gpio_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ oe_q) & own_q) == '0) && (((pad_out ^ out_q) & own_q) == '0));

    assert_pull_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pullup & pad_pulldown) == '0) &&
        ((pad_keeper & (pad_pullup | pad_pulldown)) == '0));

endmodule

bind gpio_atomic_port gpio_atomic_port_checker #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .NUM_CTRL (NUM_CTRL_REGS)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_pullup   (pad_pullup),
    .pad_pulldown (pad_pulldown),
    .pad_keeper   (pad_keeper),
    .own_q        (own_q),
    .oe_q         (oe_q),
    .out_q        (out_q),
    .level_q      (level_q)
);

// File: tb/gpio_atomic_port_bench.sv
`timescale 1ns/1ps
module gpio_atomic_port_bench;

    localparam int NP = 32;
    localparam int NF = 8;
    localparam int AW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [NP-1:0]   bus_wdata = '0;
    logic [NP-1:0]   bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe, pad_pullup, pad_pulldown, pad_keeper;
    logic [NF*NP-1:0] periph_out = '0;
    logic [NF*NP-1:0] periph_oe = '0;

    always #2.5 clk = ~clk;

    gpio_atomic_port u_gpio_atomic_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
        .pad_pulldown(pad_pulldown), .pad_keeper(pad_keeper),
        .periph_out(periph_out), .periph_oe(periph_oe)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [NP-1:0] m_reg [8];
    logic [NP-1:0] m_s1, m_s2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) m_reg[r] <= (r == 0) ? '1 : '0;
            m_s1 <= '0;
            m_s2 <= '0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            if (bus_wr && bus_addr[5:2] < 4'd8) begin
                case (bus_addr[1:0])
                    2'd0: m_reg[bus_addr[4:2]] <= bus_wdata;
                    2'd1: m_reg[bus_addr[4:2]] <= m_reg[bus_addr[4:2]] | bus_wdata;
                    2'd2: m_reg[bus_addr[4:2]] <= m_reg[bus_addr[4:2]] & ~bus_wdata;
                    default: m_reg[bus_addr[4:2]] <= m_reg[bus_addr[4:2]] ^ bus_wdata;
                endcase
            end
        end
    end

    function automatic logic [NP-1:0] exp_rdata();
        if (bus_addr[5:2] < 4'd8) return m_reg[bus_addr[4:2]];
        if (bus_addr[5:2] == 4'd8) return m_s2;
        return '0;
    endfunction

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NP-1:0] e_out, e_oe, e_pu, e_pd, e_kp;
            for (int i = 0; i < NP; i++) begin
                int f;
                f = {m_reg[7][i], m_reg[6][i], m_reg[5][i]};
                if (m_reg[0][i]) begin
                    e_out[i] = m_reg[2][i];
                    e_oe[i]  = m_reg[1][i];
                end else begin
                    e_out[i] = periph_out[f*NP + i];
                    e_oe[i]  = periph_oe[f*NP + i];
                end
                e_pu[i] = m_reg[3][i] & ~m_reg[4][i];
                e_pd[i] = m_reg[4][i] & ~m_reg[3][i];
                e_kp[i] = m_reg[3][i] & m_reg[4][i];
            end
            check(pad_out == e_out, "R8 R9 pad_out", pad_out, e_out);
            check(pad_oe == e_oe, "R8 R9 pad_oe", pad_oe, e_oe);
            check(pad_pullup == e_pu, "R10 pullup", pad_pullup, e_pu);
            check(pad_pulldown == e_pd, "R10 pulldown", pad_pulldown, e_pd);
            check(pad_keeper == e_kp, "R10 keeper", pad_keeper, e_kp);
            check(bus_rdata == exp_rdata(), "R6 R7 rdata", bus_rdata, exp_rdata());
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [1:0] op, input logic [NP-1:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = {idx, op}; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [NP-1:0] exp, input string req);
        @(negedge clk); #1;
        bus_addr = {idx, 2'b00};
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, 32'hFFFF_FFFF, "R1 ownership");
        for (int r = 1; r < 8; r++) rd(r[3:0], 32'h0, "R1 control");
        check(pad_oe == '0, "R1 pad_oe", pad_oe, '0);

        // R2..R6 alias arithmetic and read map
        wr(4'd1, 2'd0, 32'hA5A5_0F0F);
        rd(4'd1, 32'hA5A5_0F0F, "R2 plain write");
        wr(4'd1, 2'd1, 32'h00F0_0000);
        rd(4'd1, 32'hA5F5_0F0F, "R3 set alias");
        wr(4'd1, 2'd2, 32'h0000_000F);
        rd(4'd1, 32'hA5F5_0F00, "R4 clear alias");
        wr(4'd1, 2'd3, 32'hFFFF_0000);
        rd(4'd1, 32'h5A0A_0F00, "R5 toggle alias");
        @(negedge clk); #1 bus_addr = {4'd1, 2'd3}; #1;
        check(bus_rdata == 32'h5A0A_0F00, "R6 alias read", bus_rdata, 32'h5A0A_0F00);

        // R8 GPIO-owned drive
        wr(4'd2, 2'd0, 32'h1234_5678);
        #1;
        check(pad_out == 32'h1234_5678, "R8 pad_out", pad_out, 32'h1234_5678);
        check(pad_oe == 32'h5A0A_0F00, "R8 pad_oe", pad_oe, 32'h5A0A_0F00);

        // R10 pulls
        wr(4'd3, 2'd0, 32'h0000_000F);
        wr(4'd4, 2'd0, 32'h0000_000C);
        wr(4'd4, 2'd1, 32'h0000_0030);
        #1;
        check(pad_pullup == 32'h3, "R10 pullup only", pad_pullup, 32'h3);
        check(pad_keeper == 32'hC, "R10 keeper", pad_keeper, 32'hC);
        check(pad_pulldown == 32'h30, "R10 pulldown only", pad_pulldown, 32'h30);

        // R9 peripheral functions: pin p uses function p on pins 0..7
        for (int f = 0; f < NF; f++) begin
            periph_out[f*NP +: NP] = 32'h1 << f;
            periph_oe[f*NP +: NP]  = ~(32'h1 << f);
        end
        wr(4'd5, 2'd0, 32'h0000_00AA);
        wr(4'd6, 2'd0, 32'h0000_00CC);
        wr(4'd7, 2'd0, 32'h0000_00F0);
        wr(4'd0, 2'd2, 32'h0000_00FF);
        #1;
        check(pad_out == 32'h1234_56FF, "R9 peripheral out", pad_out, 32'h1234_56FF);
        check(pad_oe[7:0] == 8'h00, "R9 peripheral oe", {24'h0, pad_oe[7:0]}, 32'h0);

        // R7 synchronised level and ignored writes
        @(negedge clk); #1;
        pad_in = 32'hDEAD_BEEF; bus_addr = {4'd8, 2'd0};
        @(negedge clk); #1;
        check(bus_rdata == 32'h0, "R7 one edge", bus_rdata, 32'h0);
        @(negedge clk); #1;
        check(bus_rdata == 32'hDEAD_BEEF, "R7 two edges", bus_rdata, 32'hDEAD_BEEF);
        wr(4'd8, 2'd0, 32'h0);
        rd(4'd8, 32'hDEAD_BEEF, "R7 level write ignored");
        wr(4'd12, 2'd1, 32'hFFFF_FFFF);
        rd(4'd12, 32'h0, "R7 unmapped read");
        rd(4'd0, 32'hFFFF_FF00, "R7 unmapped write ignored");

        // R11 open-drain on pin 20
        wr(4'd2, 2'd2, 32'h0010_0000);
        #1;
        check(pad_oe[20] == 1'b0, "R11 released", {31'h0, pad_oe[20]}, 32'h0);
        wr(4'd1, 2'd3, 32'h0010_0000);
        #1;
        check({pad_oe[20], pad_out[20]} == 2'b10, "R11 driven low",
              {30'h0, pad_oe[20], pad_out[20]}, 32'h2);
        wr(4'd1, 2'd3, 32'h0010_0000);
        #1;
        check(pad_oe[20] == 1'b0, "R11 released again", {31'h0, pad_oe[20]}, 32'h0);

        // Random traffic against the model
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_addr  = AW'($urandom_range(0, 47));
            bus_wdata = $urandom();
            pad_in    = $urandom();
            for (int f = 0; f < NF; f++) begin
                periph_out[f*NP +: NP] = $urandom();
                periph_oe[f*NP +: NP]  = $urandom();
            end
        end
        @(negedge clk); #1 bus_wr = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule